// File: doc/BRIEF.md
# Byte-Serial AES-128 Cipher Engine

This block encrypts or decrypts one 128-bit block under a 128-bit key. It is built for low area. The host feeds the block and the key together, one byte per clock. It then pulses a start input, waits for the busy flag to drop, and reads the 16 result bytes back one per clock. A mode input chosen at start selects the forward or the inverse cipher.

Only one substitution unit exists. It is computed from field inversion and serves both directions. It handles the state bytes one per cycle and also the four key-schedule substitutions of each round. Round keys are derived in place from the previous one. In inverse mode the host supplies the tenth round key, and the schedule is walked backwards with the round constants taken in descending order. Every operation takes the same number of cycles.

Top module: `aes8_core`

## Requirements
- R1: While rst_ni is low, busy_o is 0 and data_o is 0.
- R2: While busy_o is low and load_i is high, each rising edge stores data_i as the next block byte and key_i as the next key byte. The first edge of a load burst writes byte 0. Byte 0 is the leftmost byte of the usual hexadecimal notation.
- R3: With busy_o low, start_i high at a rising edge raises busy_o after that edge. busy_o then stays high for exactly 210 cycles, falls once, and stays low until the next start.
- R4: With inv_i low at start, the result is the AES-128 encryption of the loaded block under the loaded key. Two checks apply: key 000102030405060708090a0b0c0d0e0f with block 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a, and key 2b7e151628aed2a6abf7158809cf4f3c with block 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R5: While busy_o is low and unload_i is high, each rising edge places the next result byte on data_o. Byte 0 appears after the first edge of the burst. Between bursts, data_o holds its last value.
- R6: With inv_i high at start and the tenth round key loaded as the key, the result is the decryption of the loaded block. The tenth round keys are 13111d7fe3944a17f307a78b4d2b30c5 and d014f9a8c9ee2589e13f0cc8b6630ca6 for the two R4 keys.
- R7: A start_i pulse while busy_o is high neither restarts nor lengthens the operation.
- R8: load_i while busy_o is high changes neither the result nor the key in use.
- R9: unload_i while busy_o is high leaves data_o unchanged.
- R10: With busy_o low and start_i low, busy_o stays low.
- R11: Dropping load_i or unload_i for one cycle or more resets the byte position, so the next burst begins again at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 8 | Block byte for loading |
| key_i | input | 8 | Key byte for loading, cipher key or tenth round key |
| load_i | input | 1 | Load one block byte and one key byte per cycle |
| unload_i | input | 1 | Shift out one result byte per cycle |
| start_i | input | 1 | Begin an operation |
| inv_i | input | 1 | 1 selects decryption, sampled at start |
| data_o | output | 8 | Result byte |
| busy_o | output | 1 | Operation in progress |

## Verification
The core has no tunable parameters. The bench builds it with the fixed AES-128 constants: 16 state bytes, 4 key-schedule substitutions per round and 10 rounds, which gives a 210-cycle busy window. Both published key/block pairs run through encryption and through decryption from the tenth round key, so every forward and reverse round constant is exercised, including the 1b/36 wrap. One run fires load, start and unload in the middle of busy and then checks the window length and the ciphertext.

// File: rtl/aes8_pkg.sv
package aes8_pkg;
  localparam int NB     = 16;
  localparam int NW     = 4;
  localparam int NR     = 10;
  localparam int CNT_W  = $clog2(NB);
  localparam int LATENCY = NR * (NB + NW + 1);

  typedef logic [7:0]           byte_t;
  typedef logic [NB-1:0][7:0]   blk_t;
  typedef logic [NW-1:0][7:0]   word_t;
  typedef enum logic [1:0] {PH_IDLE, PH_SUB, PH_KEY, PH_MIX} phase_e;

  function automatic byte_t xt(byte_t b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t xt_inv(byte_t b);
    return b[0] ? (((b ^ 8'h1b) >> 1) | 8'h80) : (b >> 1);
  endfunction

  function automatic byte_t gmul(byte_t a, byte_t b);
    byte_t p, aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xt(aa);
    end
    return p;
  endfunction

  // x^254 gives the multiplicative inverse, 0 maps to 0
  function automatic byte_t ginv(byte_t x);
    byte_t p, r;
    p = x;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic byte_t aff_fwd(byte_t b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic byte_t aff_inv(byte_t b);
    return {b[6:0], b[7]} ^ {b[4:0], b[7:5]} ^ {b[1:0], b[7:2]} ^ 8'h05;
  endfunction
endpackage

// File: rtl/aes8_sbox.sv
module aes8_sbox
  import aes8_pkg::*;
(
  input  byte_t x_i,
  input  logic  inv_i,
  output byte_t y_o
);
  byte_t pre, g;
  assign pre = inv_i ? aff_inv(x_i) : x_i;
  assign g   = ginv(pre);
  assign y_o = inv_i ? g : aff_fwd(g);
endmodule

// File: rtl/aes8_key_step.sv
module aes8_key_step
  import aes8_pkg::*;
(
  input  blk_t  key_i,
  input  word_t sw_i,
  input  byte_t rcon_i,
  input  logic  inv_i,
  output blk_t  key_o
);
  word_t t;
  always_comb begin
    t    = sw_i;
    t[0] = sw_i[0] ^ rcon_i;
  end

  always_comb begin
    key_o = key_i;
    for (int j = 0; j < NW; j++) begin
      if (!inv_i) begin
        key_o[j]      = key_i[j] ^ t[j];
        key_o[4 + j]  = key_i[4 + j]  ^ key_o[j];
        key_o[8 + j]  = key_i[8 + j]  ^ key_o[4 + j];
        key_o[12 + j] = key_i[12 + j] ^ key_o[8 + j];
      end else begin
        key_o[12 + j] = key_i[12 + j] ^ key_i[8 + j];
        key_o[8 + j]  = key_i[8 + j]  ^ key_i[4 + j];
        key_o[4 + j]  = key_i[4 + j]  ^ key_i[j];
        key_o[j]      = key_i[j] ^ t[j];
      end
    end
  end
endmodule

// File: rtl/aes8_lin.sv
module aes8_lin
  import aes8_pkg::*;
(
  input  blk_t st_i,
  input  blk_t rk_i,
  input  logic inv_i,
  input  logic last_i,
  output blk_t st_o
);
  blk_t sr, isr, mx, ark, imx;

  always_comb begin
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        sr[r + 4*c]  = st_i[r + 4*((c + r) % 4)];
        isr[r + 4*c] = st_i[r + 4*((c + 4 - r) % 4)];
      end
  end

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      mx[4*c+0] = xt(sr[4*c]) ^ xt(sr[4*c+1]) ^ sr[4*c+1] ^ sr[4*c+2] ^ sr[4*c+3];
      mx[4*c+1] = sr[4*c] ^ xt(sr[4*c+1]) ^ xt(sr[4*c+2]) ^ sr[4*c+2] ^ sr[4*c+3];
      mx[4*c+2] = sr[4*c] ^ sr[4*c+1] ^ xt(sr[4*c+2]) ^ xt(sr[4*c+3]) ^ sr[4*c+3];
      mx[4*c+3] = xt(sr[4*c]) ^ sr[4*c] ^ sr[4*c+1] ^ sr[4*c+2] ^ xt(sr[4*c+3]);
    end
  end

  assign ark = isr ^ rk_i;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      imx[4*c+0] = gmul(ark[4*c], 8'h0e) ^ gmul(ark[4*c+1], 8'h0b)
                 ^ gmul(ark[4*c+2], 8'h0d) ^ gmul(ark[4*c+3], 8'h09);
      imx[4*c+1] = gmul(ark[4*c], 8'h09) ^ gmul(ark[4*c+1], 8'h0e)
                 ^ gmul(ark[4*c+2], 8'h0b) ^ gmul(ark[4*c+3], 8'h0d);
      imx[4*c+2] = gmul(ark[4*c], 8'h0d) ^ gmul(ark[4*c+1], 8'h09)
                 ^ gmul(ark[4*c+2], 8'h0e) ^ gmul(ark[4*c+3], 8'h0b);
      imx[4*c+3] = gmul(ark[4*c], 8'h0b) ^ gmul(ark[4*c+1], 8'h0d)
                 ^ gmul(ark[4*c+2], 8'h09) ^ gmul(ark[4*c+3], 8'h0e);
    end
  end

  always_comb begin
    if (!inv_i) st_o = (last_i ? sr : mx) ^ rk_i;
    else        st_o = last_i ? ark : imx;
  end
endmodule

// File: rtl/aes8_core.sv
module aes8_core
  import aes8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] data_i,
  input  logic [7:0] key_i,
  input  logic       load_i,
  input  logic       unload_i,
  input  logic       start_i,
  input  logic       inv_i,
  output logic [7:0] data_o,
  output logic       busy_o
);
  blk_t             st_q, key_q, key_nx, lin_out;
  word_t            sw_q;
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q, io_ptr_q;
  logic [3:0]       rnd_q;
  byte_t            rcon_q, dout_q, sb_in, sb_out, kbyte;
  logic             mode_q, busy_q, sb_inv, last_rnd;
  logic [1:0]       rot_j;

  // RotWord: substitution slot j reads word-3 byte j+1
  assign rot_j  = cnt_q[1:0] + 2'd1;
  assign kbyte  = mode_q ? (key_q[{2'b11, rot_j}] ^ key_q[{2'b10, rot_j}])
                         : key_q[{2'b11, rot_j}];
  assign sb_in  = (ph_q == PH_KEY) ? kbyte : st_q[cnt_q];
  assign sb_inv = (ph_q == PH_SUB) && mode_q;
  assign last_rnd = (rnd_q == 4'(NR));

  aes8_sbox u_sbox (.x_i(sb_in), .inv_i(sb_inv), .y_o(sb_out));

  aes8_key_step u_key_step (
    .key_i(key_q), .sw_i(sw_q), .rcon_i(rcon_q), .inv_i(mode_q), .key_o(key_nx)
  );

  aes8_lin u_lin (
    .st_i(st_q), .rk_i(key_nx), .inv_i(mode_q), .last_i(last_rnd), .st_o(lin_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= '0;
      key_q    <= '0;
      sw_q     <= '0;
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      io_ptr_q <= '0;
      rnd_q    <= '0;
      rcon_q   <= '0;
      dout_q   <= '0;
      mode_q   <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            busy_q   <= 1'b1;
            mode_q   <= inv_i;
            st_q     <= st_q ^ key_q;
            rnd_q    <= 4'd1;
            cnt_q    <= '0;
            io_ptr_q <= '0;
            rcon_q   <= inv_i ? 8'h36 : 8'h01;
            ph_q     <= PH_SUB;
          end else begin
            if (load_i) begin
              st_q[io_ptr_q]  <= data_i;
              key_q[io_ptr_q] <= key_i;
            end
            if (unload_i) dout_q <= st_q[io_ptr_q];
            io_ptr_q <= (load_i || unload_i) ? io_ptr_q + 1'b1 : '0;
          end
        end
        PH_SUB: begin
          st_q[cnt_q] <= sb_out;
          cnt_q       <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NB - 1)) ph_q <= PH_KEY;
        end
        PH_KEY: begin
          sw_q[cnt_q[1:0]] <= sb_out;
          if (cnt_q == CNT_W'(NW - 1)) begin
            cnt_q <= '0;
            ph_q  <= PH_MIX;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q   <= lin_out;
          key_q  <= key_nx;
          rcon_q <= mode_q ? xt_inv(rcon_q) : xt(rcon_q);
          if (last_rnd) begin
            busy_q <= 1'b0;
            ph_q   <= PH_IDLE;
          end else begin
            rnd_q <= rnd_q + 4'd1;
            ph_q  <= PH_SUB;
          end
        end
      endcase
    end
  end

  assign data_o = dout_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/aes8_core_chk.sv
module aes8_core_chk
  import aes8_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic [7:0] data_o
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 16'd1;
    else             busy_cnt <= '0;
  end

  always @(posedge clk_i)
    if (!rst_ni) AST_RESET_IDLE: assert (!busy_o && data_o == 8'h00); // R1

  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R3
  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == 16'(LATENCY))); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_cnt < 16'(LATENCY))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o); // R10
  AST_DOUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(data_o)); // R9
endmodule

bind aes8_core aes8_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .data_o(data_o)
);

// File: tb/aes8_core_bench.sv
module aes8_core_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] data_i = '0, key_i = '0;
  logic       load_i = 1'b0, unload_i = 1'b0, start_i = 1'b0, inv_i = 1'b0;
  logic [7:0] data_o;
  logic       busy_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [127:0] K1  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1  = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] IK1 = 128'h13111d7fe3944a17f307a78b4d2b30c5;
  localparam logic [127:0] K2  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] IK2 = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
  localparam int LAT = 210;

  always #4 clk_i = ~clk_i;

  aes8_core u_aes8_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .key_i(key_i),
    .load_i(load_i), .unload_i(unload_i), .start_i(start_i), .inv_i(inv_i),
    .data_o(data_o), .busy_o(busy_o)
  );

  function automatic logic [7:0] bt(logic [127:0] v, int i);
    return v[127 - 8*i -: 8];
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_blk(logic [127:0] d, logic [127:0] k);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      load_i = 1'b1;
      data_i = bt(d, i);
      key_i  = bt(k, i);
    end
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  // pulses start, checks busy rise, window length and a single fall
  task automatic run_op(bit inv);
    int n;
    int rises;
    inv_i   = inv;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R3 busy after start", int'(busy_o), 1);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    check("R3 busy cycles", n, LAT);
    rises = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      if (busy_o) rises++;
    end
    check("R10 busy stays low after fall", rises, 0);
  endtask

  task automatic unload_chk(logic [127:0] exp, string req);
    unload_i = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      check(req, int'(data_o), int'(bt(exp, i)));
    end
    unload_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 data in reset", int'(data_o), 0);
  endtask

  task automatic t_vector(logic [127:0] k, logic [127:0] p, logic [127:0] c,
                          logic [127:0] ik);
    load_blk(p, k);
    run_op(1'b0);
    unload_chk(c, "R2 R4 R5 ciphertext");
    load_blk(c, ik);
    run_op(1'b1);
    unload_chk(p, "R6 plaintext");
  endtask

  // R7 R8 R9: stimulus in the middle of busy must be ignored
  task automatic t_busy_ignore;
    int n;
    logic [7:0] held;
    load_blk(P2, K2);
    inv_i   = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    held = data_o;
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      load_i   = (n >= 5 && n < 40);
      data_i   = 8'(n * 7);
      key_i    = 8'(n * 13);
      start_i  = (n == 50 || n == 120);
      unload_i = (n >= 60 && n < 90);
      if (n >= 61 && n <= 91) check("R9 data_o frozen", int'(data_o), int'(held));
      if (n > 95) begin
        load_i = 1'b0; unload_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    load_i = 1'b0; unload_i = 1'b0; start_i = 1'b0;
    check("R7 busy cycles with start in busy", n, LAT);
    @(negedge clk_i);
    unload_chk(C2, "R8 ciphertext after load in busy");
  endtask

  task automatic t_restart;
    unload_i = 1'b1;
    for (int i = 0; i < 6; i++) @(negedge clk_i);
    check("R5 partial unload byte 5", int'(data_o), int'(bt(C2, 5)));
    unload_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R5 data_o held between bursts", int'(data_o), int'(bt(C2, 5)));
    unload_chk(C2, "R11 unload restarts at byte 0");
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_vector(K1, P1, C1, IK1);
    t_vector(K2, P2, C2, IK2);
    t_busy_ignore();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule